// File: doc/BRIEF.md
# Serial-Access Byte Memory with Write Guarding

This block is a serial peripheral slave that works in clock modes 0 and 3. It receives one-byte commands and uses them to serve a small byte-wide memory held inside the block. The same bus gives access to a status register. That register holds a write-enable flag, a busy flag, a two-bit block-lock code and a status-lock bit. The status-lock bit works together with an active-low write-protect pin.

Memory writes collect up to one 64-byte page in a buffer. The buffered bytes are committed only when chip select is released on a whole-byte boundary. The commit then runs as an internal write cycle whose length is a parameter in clock cycles. A reset-active inhibit input blocks all command traffic while it is asserted.

The bus pins are expected to be synchronous to `clk`, with each SCK half-period lasting several `clk` cycles. Every bus event therefore appears as an edge seen by the system clock.

Top module: `spi_guarded_mem`

## Requirements
- R1: SI is captured on each rising SCK edge and SO moves on each falling SCK edge. Opcode, address and data travel most-significant bit first. Clock modes 0 and 3 give the same results. `so_oe` is low whenever `cs_n` is high.
- R2: Opcode 03h is followed by a 16-bit address, of which the low ADDR_W bits are used. The block then returns the byte at that address and keeps returning the following addresses, one byte per 8 clocks, until `cs_n` rises.
- R3: Opcode 02h is followed by a 16-bit address and data bytes. The data bytes go to consecutive addresses, and only the low 6 address bits advance. A write therefore wraps inside its 64-byte page and overwrites the earlier bytes of that page.
- R4: A memory or status write starts its internal cycle only if `cs_n` rises after a whole, nonzero multiple of 8 data bits. In any other case the memory, the status register and the write-enable flag stay as they were.
- R5: Opcode 06h sets the write-enable flag, but only when `cs_n` rises straight after those 8 bits. If further clocks follow in the same frame, the whole frame is ignored. Opcode 04h clears the flag.
- R6: Opcode 02h and opcode 01h are ignored while the write-enable flag is 0.
- R7: The write-enable flag is 0 after reset. It also returns to 0 when an internal write cycle ends.
- R8: Opcode 05h returns the status byte repeatedly for as long as clocks continue. The status byte is laid out as follows:
  - bit 7: status-lock
  - bits 6:4: a free 3-bit configuration field
  - bits 3:2: block-lock code
  - bit 1: write-enable flag
  - bit 0: busy
- R9: The busy bit reads 1 for WR_CYCLES clocks after a commit starts. During that time opcode 05h is served and every other opcode is ignored.
- R10: Block-lock code 11 refuses memory writes, and the protected bytes can still be read. Codes 00, 01 and 10 allow memory writes.
- R11: When the status-lock bit is 1 and `wp_n` is 0, opcode 01h is refused. Driving `wp_n` to 1, or clearing the status-lock bit, allows status writes again.
- R12: While `hold_in` is 1, any frame is ignored as a whole. A frame that is ignored this way has no effect on the write-enable flag.
- R13: A status write changes bits 7:2 at the end of its internal cycle. Bits 1:0 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| wp_n | input | 1 | Write-protect pin, active low |
| hold_in | input | 1 | Reset-active inhibit; 1 blocks all commands |

## Verification
On every cycle, the assertions check four conditions:
- a commit never starts without the write-enable flag;
- the write-enable flag is 0 once a write cycle ends;
- no memory byte is written while block-lock code 11 is in force;
- a new commit never starts while one is still busy.

Only the bench scenarios can show the behaviour that depends on whole frames. This covers:
- page wrap-around and auto-increment reads;
- frames that are discarded for a partial byte or for extra clocks after 06h;
- the refusal of status writes under the pin and bit lock;
- the commands that are dropped during the busy window.

// File: rtl/spm_pkg.sv
// Shared opcodes and the command-sequencer state type.
package spm_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [3:0] {
        S_IDLE, S_OPC, S_ARM, S_ADDR, S_RDATA, S_STAT, S_WDATA, S_SDATA, S_SKIP
    } spm_state_e;
endpackage

// File: rtl/spm_edges.sv
// Bus edge detector.
// Compares SCK and CS with the values they had one clk earlier and flags each edge.
// Assumes the bus pins are already synchronous to clk.
// SCK edges are flagged only while the chip is selected.
module spm_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall
);
    logic sck_q;
    logic cs_q;

    // Hold the previous pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign sck_fall = ~sck & sck_q & ~cs_n;
    assign cs_rise  = cs_n & ~cs_q;
    assign cs_fall  = ~cs_n & cs_q;
endmodule

// File: rtl/spm_ram.sv
// Byte memory model.
// Writes are synchronous and reads are combinational.
// The contents have no reset and are defined only after they are written.
module spm_ram #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [7:0] cells [DEPTH];

    // Store one byte when requested.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spm_commit.sv
// Page buffer and internal write-cycle timer.
// Bytes are collected by page index during a write frame.
// When a commit starts, the timer runs for WR_CYCLES clocks and busy stays high for that time.
// The first PAGE clocks of the cycle scan the buffer and copy each valid byte to the memory.
// Assumes WR_CYCLES >= 2**PAGE_W.
module spm_commit #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_clr,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_data,
    input  logic                     start,
    input  logic                     drain,
    input  logic [ADDR_W-PAGE_W-1:0] page,
    output logic                     busy,
    output logic                     done,
    output logic                     ram_we,
    output logic [ADDR_W-1:0]        ram_addr,
    output logic [7:0]               ram_wdata
);
    localparam int PAGE = 1 << PAGE_W;
    localparam int TW   = $clog2(WR_CYCLES + 1);

    logic [7:0]               pbuf [PAGE];
    logic [PAGE-1:0]          pvalid;
    logic [TW-1:0]            timer;
    logic                     drain_q;
    logic [ADDR_W-PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0]        scan;
    logic                     in_scan;

    assign scan    = timer[PAGE_W-1:0];
    assign in_scan = timer < TW'(PAGE);
    assign done    = busy && (timer == TW'(WR_CYCLES - 1));

    // Capture the frame's data bytes.
    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    // Track which buffer slots hold a byte to commit.
    always_ff @(posedge clk) begin
        if (!rst_n || buf_clr || done) pvalid <= '0;
        else if (buf_we)               pvalid[buf_idx] <= 1'b1;
    end

    // Run the internal write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            timer   <= '0;
            drain_q <= 1'b0;
            page_q  <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            timer   <= '0;
            drain_q <= drain;
            page_q  <= page;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            else      timer <= timer + 1'b1;
        end
    end

    assign ram_we    = busy && drain_q && in_scan && pvalid[scan];
    assign ram_addr  = {page_q, scan};
    assign ram_wdata = pbuf[scan];

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy); // R9
endmodule

// File: rtl/spi_guarded_mem.sv
// Serial slave with a guarded byte memory.
// Decodes one-byte opcodes, keeps the status register and enforces the write-enable flag,
// the block lock and the pin-and-bit status lock.
// Assumes the bus pins are synchronous to clk and that each SCK half-period spans at least two clk cycles.
module spi_guarded_mem
    import spm_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_oe,
    input  logic wp_n,
    input  logic hold_in
);
    spm_state_e        state;
    logic [3:0]        cnt;
    logic [6:0]        rx;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        tx;
    logic              so_q;
    logic              wel, wpen;
    logic [2:0]        aux;
    logic [1:0]        bl;
    logic              got, wr_mode, st_pend;
    logic [7:2]        st_new;
    logic [PAGE_W-1:0] widx;

    logic sck_rise, sck_fall, cs_rise, cs_fall;
    logic busy, done, ram_we;
    logic [ADDR_W-1:0] ram_addr, rd_addr;
    logic [7:0] ram_wdata, ram_rdata, byte_in, status;
    logic byte_end, locked, commit_go, buf_clr, buf_we;

    spm_edges u_edges (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise), .cs_fall(cs_fall)
    );

    assign byte_in  = {rx, si};
    assign byte_end = (cnt[2:0] == 3'd7);
    assign status   = {wpen, aux, bl, wel, busy};
    assign locked   = wpen & ~wp_n;
    assign rd_addr  = (state == S_ADDR) ? {addr[ADDR_W-2:0], si} : addr + 1'b1;
    assign buf_clr  = sck_rise && state == S_ADDR && cnt == 4'd15 && wr_mode;
    assign buf_we   = sck_rise && state == S_WDATA && byte_end;
    assign commit_go = cs_rise && !hold_in && got && cnt[2:0] == 3'd0
                       && (state == S_WDATA || state == S_SDATA);

    spm_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(ram_wdata),
        .raddr(rd_addr), .rdata(ram_rdata)
    );

    spm_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_commit (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(widx),
        .buf_data(byte_in), .start(commit_go), .drain(state == S_WDATA),
        .page(addr[ADDR_W-1:PAGE_W]), .busy(busy), .done(done),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    // Sequence the frames, hold the status bits and shift the output data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;  cnt <= '0;  rx <= '0;  addr <= '0;  tx <= '0;  so_q <= 1'b0;
            wel <= 1'b0;  wpen <= 1'b0;  aux <= '0;  bl <= '0;  got <= 1'b0;
            wr_mode <= 1'b0;  st_pend <= 1'b0;  st_new <= '0;  widx <= '0;
        end else begin
            if (done) begin
                wel <= 1'b0;
                if (st_pend) begin
                    wpen    <= st_new[7];
                    aux     <= st_new[6:4];
                    bl      <= st_new[3:2];
                    st_pend <= 1'b0;
                end
            end
            if (cs_rise) begin
                state <= S_IDLE;
                if (state == S_ARM && !hold_in) wel <= 1'b1;
                if (commit_go && state == S_SDATA) st_pend <= 1'b1;
            end else if (cs_fall) begin
                state <= hold_in ? S_SKIP : S_OPC;
                cnt   <= '0;
            end else if (hold_in && state != S_IDLE) begin
                state <= S_SKIP;
            end else if (sck_rise) begin
                rx  <= byte_in[6:0];
                cnt <= (state == S_ADDR) ? cnt + 4'd1 : {1'b0, cnt[2:0] + 3'd1};
                case (state)
                    S_OPC: if (byte_end) begin
                        if (busy && byte_in != OP_RDSR) state <= S_SKIP;
                        else case (byte_in)
                            OP_WREN:  state <= S_ARM;
                            OP_WRDI:  begin wel <= 1'b0; state <= S_SKIP; end
                            OP_RDSR:  begin tx <= status; state <= S_STAT; end
                            OP_WRSR:  begin got <= 1'b0; state <= (wel && !locked) ? S_SDATA : S_SKIP; end
                            OP_READ:  begin wr_mode <= 1'b0; state <= S_ADDR; end
                            OP_WRITE: begin wr_mode <= 1'b1; state <= (wel && bl != 2'b11) ? S_ADDR : S_SKIP; end
                            default:  state <= S_SKIP;
                        endcase
                    end
                    S_ARM:  state <= S_SKIP;
                    S_ADDR: begin
                        addr <= rd_addr;
                        if (cnt == 4'd15) begin
                            if (wr_mode) begin
                                state <= S_WDATA;
                                widx  <= {addr[PAGE_W-2:0], si};
                                got   <= 1'b0;
                            end else begin
                                state <= S_RDATA;
                                tx    <= ram_rdata;
                            end
                        end
                    end
                    S_RDATA: if (byte_end) begin addr <= rd_addr; tx <= ram_rdata; end
                    S_STAT:  if (byte_end) tx <= status;
                    S_WDATA: if (byte_end) begin got <= 1'b1; widx <= widx + 1'b1; end
                    S_SDATA: if (byte_end) begin got <= 1'b1; st_new <= byte_in[7:2]; end
                    default: ;
                endcase
            end else if (sck_fall && (state == S_RDATA || state == S_STAT)) begin
                so_q <= tx[7];
                tx   <= {tx[6:0], 1'b0};
            end
        end
    end

    assign so    = so_q;
    assign so_oe = ~cs_n;

    AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) commit_go |-> wel); // R6
    AST_WEL_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !wel); // R7
    AST_BL_GUARD: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> bl != 2'b11); // R10
endmodule

// File: tb/test_spi_guarded_mem.sv
module test_spi_guarded_mem;
    localparam int WR = 400;
    localparam int H  = 4;

    logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, wp_n = 1, hold_in = 0;
    logic so, so_oe;
    bit   m3 = 0;
    int   tests = 0, fails = 0;
    logic [7:0] mdl [512];
    logic [7:0] d, s1, s2;

    always #4 clk = ~clk;

    spi_guarded_mem #(.WR_CYCLES(WR)) i_spi_guarded_mem (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .wp_n(wp_n), .hold_in(hold_in));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R1: output enable follows the select line on every clock.
    always @(negedge clk) if (rst_n) begin
        tests++;
        if (so_oe !== ~cs_n) begin
            fails++;
            $display("FAIL R1 so_oe actual=%b expected=%b", so_oe, ~cs_n);
        end
    end

    task automatic sel();
        @(negedge clk) sck = m3; cs_n = 0;
        repeat (H) @(negedge clk);
    endtask
    task automatic desel();
        @(negedge clk) if (!m3) sck = 0;
        repeat (H) @(negedge clk);
        cs_n = 1;
        repeat (H) @(negedge clk);
    endtask
    task automatic bitx(input logic b, output logic r);
        @(negedge clk) sck = 0; si = b;
        repeat (H) @(negedge clk);
        r = so; sck = 1;
        repeat (H - 1) @(negedge clk);
    endtask
    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) bitx(b[i], r[i]);
    endtask
    task automatic op1(input logic [7:0] op);
        logic [7:0] x;
        sel(); xfer(op, x); desel();
    endtask
    task automatic rdsr(output logic [7:0] st);
        logic [7:0] x;
        sel(); xfer(8'h05, x); xfer(8'h00, st); desel();
    endtask
    task automatic wrsr(input logic [7:0] v);
        logic [7:0] x;
        sel(); xfer(8'h01, x); xfer(v, x); desel();
    endtask
    task automatic wr(input logic [15:0] a, input logic [7:0] q[$]);
        logic [7:0] x;
        sel(); xfer(8'h02, x); xfer(a[15:8], x); xfer(a[7:0], x);
        foreach (q[i]) xfer(q[i], x);
        desel();
    endtask
    // Reference update for an accepted write: the low 6 bits advance, the page stays.
    task automatic mdl_wr(input logic [15:0] a, input logic [7:0] q[$]);
        foreach (q[i]) begin
            logic [5:0] lo;
            lo = a[5:0] + 6'(i);
            mdl[{a[8:6], lo}] = q[i];
        end
    endtask
    task automatic rd_chk(input string tag, input logic [15:0] a, input int n);
        logic [7:0] x;
        sel(); xfer(8'h03, x); xfer(a[15:8], x); xfer(a[7:0], x);
        for (int i = 0; i < n; i++) begin
            logic [8:0] ad;
            ad = a[8:0] + 9'(i);
            xfer(8'h00, x);
            chk(tag, x, mdl[ad]);
        end
        desel();
    endtask
    task automatic settle();
        repeat (WR + 20) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] x;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1 so_oe idle", {7'd0, so_oe}, 8'h00);
        rdsr(d); chk("R7 status after reset", d, 8'h00);

        op1(8'h06); rdsr(d); chk("R5 WEL set by 06h", d, 8'h02);
        op1(8'h04); rdsr(d); chk("R5 WEL cleared by 04h", d, 8'h00);

        // R8: status repeats while clocked.
        op1(8'h06);
        sel(); xfer(8'h05, x); xfer(8'h00, s1); xfer(8'h00, s2); desel();
        chk("R8 status first", s1, 8'h02); chk("R8 status repeat", s2, 8'h02);

        // R2/R9: write four bytes, busy visible, then stream them back.
        wr(16'h0010, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}); mdl_wr(16'h0010, '{8'hA0, 8'hA1, 8'hA2, 8'hA3});
        rdsr(d); chk("R9 WIP during cycle", d, 8'h03);
        settle();
        rdsr(d); chk("R7 WEL clear after cycle", d, 8'h00);
        rd_chk("R2 streaming read", 16'h0010, 4);

        // R3: page wrap.
        op1(8'h06);
        wr(16'h003E, '{8'h11, 8'h22, 8'h33, 8'h44}); mdl_wr(16'h003E, '{8'h11, 8'h22, 8'h33, 8'h44});
        settle();
        rd_chk("R3 page end", 16'h003E, 2);
        rd_chk("R3 wrapped start", 16'h0000, 2);
        rd_chk("R3 other bytes kept", 16'h0010, 1);

        // R4: partial byte discards the frame.
        op1(8'h06);
        sel(); xfer(8'h02, x); xfer(8'h00, x); xfer(8'h10, x); xfer(8'h55, x);
        for (int i = 0; i < 3; i++) bitx(1'b1, x[i]);
        desel();
        rdsr(d); chk("R4 no cycle, WEL kept", d, 8'h02);
        rd_chk("R4 memory unchanged", 16'h0010, 1);
        op1(8'h04);

        // R5: write-enable followed in the same frame by a write.
        sel(); xfer(8'h06, x); xfer(8'h02, x); xfer(8'h00, x); xfer(8'h10, x); xfer(8'h77, x); desel();
        rdsr(d); chk("R5 chained frame ignored", d, 8'h00);
        rd_chk("R5 memory unchanged", 16'h0010, 1);

        // R6: no write without WEL.
        wr(16'h0010, '{8'h99}); rdsr(d); chk("R6 no cycle without WEL", d, 8'h00);
        rd_chk("R6 memory unchanged", 16'h0010, 1);

        // R10/R13: block lock 11.
        op1(8'h06); wrsr(8'h0C); settle();
        rdsr(d); chk("R13 status written", d, 8'h0C);
        op1(8'h06); wr(16'h0010, '{8'h99});
        rdsr(d); chk("R10 locked write refused", d, 8'h0E);
        rd_chk("R10 protected readable", 16'h0010, 1);
        wrsr(8'h00); settle(); rdsr(d); chk("R10 lock released", d, 8'h00);

        // R11/R13: pin plus bit lock.
        op1(8'h06); wrsr(8'hFF); settle();
        rdsr(d); chk("R13 low bits not writable", d, 8'hFC);
        @(negedge clk) wp_n = 0;
        op1(8'h06); wrsr(8'h00); settle();
        rdsr(d); chk("R11 status write refused", d, 8'hFE);
        @(negedge clk) wp_n = 1;
        wrsr(8'h00); settle();
        rdsr(d); chk("R11 pin high re-allows", d, 8'h00);

        // R9: commands during busy are dropped.
        op1(8'h06); wr(16'h0030, '{8'h5A}); mdl_wr(16'h0030, '{8'h5A});
        wrsr(8'h0C); settle();
        rdsr(d); chk("R9 status write in busy dropped", d, 8'h00);
        rd_chk("R9 committed byte", 16'h0030, 1);

        // R12: inhibit.
        @(negedge clk) hold_in = 1;
        op1(8'h06);
        @(negedge clk) hold_in = 0;
        rdsr(d); chk("R12 inhibited frame ignored", d, 8'h00);

        // R1: clock mode 3.
        @(negedge clk) m3 = 1; sck = 1;
        repeat (H) @(negedge clk);
        op1(8'h06);
        wr(16'h0040, '{8'hC3, 8'h3C}); mdl_wr(16'h0040, '{8'hC3, 8'h3C});
        settle();
        rd_chk("R1 mode 3 read", 16'h0040, 2);
        rdsr(d); chk("R1 mode 3 status", d, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule